// File: doc/BRIEF.md
# Word-Packed UART Transmitter

This block is the send half of a serial port whose host side is 32 bits wide. Software first sets how many characters the next transfer holds. It then pushes 32-bit words into a small word queue, each word carrying up to four characters. An unpacker takes one word at a time from the queue and hands its bytes, lowest byte first, to a serialiser. The serialiser drives them on the line as 8-N-1 frames, with a fixed number of clocks per bit.

The character count, not the number of words, decides when the transfer ends. The bytes left unused in the last word are dropped. When the last character has left the line, a sticky ready flag is raised, and a clear command lowers it. Status outputs show whether the queue has room, whether the whole transmitter is empty, and whether the queue level is at or below the watermark. A count written at the wrong moment is dropped and raises a sticky error. A reset command empties the queue and stops the transmitter.

Unpacker states: `UP_IDLE` (waits for a nonzero remaining count and a queued word; pops it → `UP_ISSUE`), `UP_ISSUE` (offers the selected byte; serialiser accepts → `UP_WAIT`), `UP_WAIT` (waits for the serialiser; count exhausted → `UP_DONE`, word used up → `UP_IDLE`, else → `UP_ISSUE`), `UP_DONE` (one cycle, raises the ready flag → `UP_IDLE`). Serialiser states: `S_IDLE` (line high; start → `S_START`), `S_START` (line low one bit → `S_DATA`), `S_DATA` (eight bits, LSB first → `S_STOP`), `S_STOP` (line high one bit → `S_IDLE`). The reset command sends both machines to their idle state.

Top module: `wptx_top`

## Requirements
- R1: After reset the line is high, `room` = 1, `all_empty` = 1, `done_flag` = 0, `cnt_err` = 0 and `wm_low` = 1.
- R2: Within a word, byte j sits in bits [8j+7:8j] and is sent in order j = 0,1,2,3, so the lowest byte goes first.
- R3: Each character is one low start bit, eight data bits LSB first and one high stop bit, each bit lasting `BIT_CLKS` clocks. The line idles high.
- R4: Exactly the programmed number of characters is sent. A count may span several words, and the bytes of the final word beyond the count are never sent.
- R5: `room` is 0 while the queue holds `DEPTH` words. A push into a full queue is dropped.
- R6: `done_flag` is set in the cycle after the last character's stop bit ends. It stays set until `clr_done` or `tx_rst`, and a set in the same cycle as `clr_done` wins.
- R7: A count write is taken only while the queue is empty and the unpacker is in `UP_IDLE`. Otherwise it is ignored, nothing is sent, and `cnt_err` goes to 1 and stays there.
- R8: `tx_rst` has priority over all other inputs. In the next cycle the queue is empty, the remaining count is zero, both machines are idle, and `cnt_err` and `done_flag` are 0.
- R9: `all_empty` is 1 exactly when the queue is empty, the unpacker is in `UP_IDLE` and the serialiser is in `S_IDLE`.
- R10: `wm_low` is 1 while the queue level is at or below `WM_LEVEL` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Write the character count |
| cnt_val | input | CNT_W | Character count for the next transfer |
| word_wr | input | 1 | Push one packed word |
| word_data | input | 32 | Packed word, byte 0 in bits 7:0 |
| tx_rst | input | 1 | Command: reset the transmitter |
| clr_done | input | 1 | Command: clear the ready flag |
| txd | output | 1 | Serial line, idles high |
| room | output | 1 | Queue can take another word |
| all_empty | output | 1 | Queue, unpacker and serialiser all idle |
| done_flag | output | 1 | Sticky: programmed transfer drained |
| cnt_err | output | 1 | Sticky: a count write was rejected |
| wm_low | output | 1 | Queue level at or below the watermark |

## Verification
The assertions assume that `tx_rst` and `clr_done` are single-cycle pulses. They also assume that a count write is the only way for `cnt_err` to rise, and a command the only way for `done_flag` to fall. The bench drives every input at the falling clock edge and holds each strobe high for one cycle. It waits on `room` before each push, except in the scenario that fills the queue on purpose, so a dropped push never happens by accident. It never pulses `tx_rst` in the middle of a frame, so the line monitor always sees complete frames.

// File: rtl/wptx_pkg.sv
package wptx_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        UP_IDLE,
        UP_ISSUE,
        UP_WAIT,
        UP_DONE
    } up_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } ser_state_t;
endpackage

// File: rtl/wptx_fifo.sv
module wptx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [LW-1:0]    level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/wptx_baud.sv
module wptx_baud #(
    parameter int BIT_CLKS = 868
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(BIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (restart || !run || tick)  cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wptx_ser.sv
module wptx_ser
    import wptx_pkg::*;
#(
    parameter int BIT_CLKS = 868
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [LANE_W-1:0] din,
    output logic              ready,
    output logic              txd
);
    ser_state_t        state, state_nx;
    logic [LANE_W-1:0] shreg;
    logic [2:0]        bitn;
    logic              tick, take;

    assign take = start && (state == S_IDLE) && !abort;

    wptx_baud #(.BIT_CLKS(BIT_CLKS)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take),
        .run     (state != S_IDLE),
        .tick    (tick)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (take) state_nx = S_START;
            S_START: if (tick) state_nx = S_DATA;
            S_DATA:  if (tick && bitn == 3'd7) state_nx = S_STOP;
            S_STOP:  if (tick) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= S_IDLE;
        else if (abort) state <= S_IDLE;
        else            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            bitn  <= '0;
        end else if (take) begin
            shreg <= din;
            bitn  <= '0;
        end else if (state == S_DATA && tick) begin
            shreg <= {1'b1, shreg[LANE_W-1:1]};
            bitn  <= bitn + 1'b1;
        end
    end

    always_comb begin
        ready = (state == S_IDLE);
        unique case (state)
            S_START: txd = 1'b0;
            S_DATA:  txd = shreg[0];
            default: txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/wptx_unpack.sv
module wptx_unpack
    import wptx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    abort,
    input  logic                    cnt_load,
    input  logic [CNT_W-1:0]        cnt_val,
    input  logic                    q_empty,
    input  logic [LANES*LANE_W-1:0] q_head,
    input  logic                    ser_ready,
    output logic                    q_pop,
    output logic                    ser_start,
    output logic [LANE_W-1:0]       ser_byte,
    output logic                    idle,
    output logic                    done_pulse
);
    up_state_t               state, state_nx;
    logic [CNT_W-1:0]        remain;
    logic [IDX_W-1:0]        idx;
    logic [LANES*LANE_W-1:0] word_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            UP_IDLE:  if (remain != '0 && !q_empty) state_nx = UP_ISSUE;
            UP_ISSUE: if (ser_ready) state_nx = UP_WAIT;
            UP_WAIT: begin
                if (ser_ready) begin
                    if (remain == '0)    state_nx = UP_DONE;
                    else if (idx == '0)  state_nx = UP_IDLE;
                    else                 state_nx = UP_ISSUE;
                end
            end
            UP_DONE:  state_nx = UP_IDLE;
            default:  state_nx = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= UP_IDLE;
        else if (abort) state <= UP_IDLE;
        else            state <= state_nx;
    end

    always_comb begin
        q_pop      = 1'b0;
        ser_start  = 1'b0;
        done_pulse = 1'b0;
        idle       = 1'b0;
        ser_byte   = word_q[idx*LANE_W +: LANE_W];
        unique case (state)
            UP_IDLE: begin
                idle  = 1'b1;
                q_pop = (remain != '0) && !q_empty && !abort;
            end
            UP_ISSUE: ser_start  = ser_ready && !abort;
            UP_DONE:  done_pulse = !abort;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            idx    <= '0;
            word_q <= '0;
        end else if (abort) begin
            remain <= '0;
            idx    <= '0;
        end else begin
            if (cnt_load && state == UP_IDLE) remain <= cnt_val;
            if (q_pop) begin
                word_q <= q_head;
                idx    <= '0;
            end
            if (ser_start) begin
                remain <= remain - 1'b1;
                idx    <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wptx_top.sv
module wptx_top
    import wptx_pkg::*;
#(
    parameter int BIT_CLKS = 868,
    parameter int DEPTH    = 4,
    parameter int CNT_W    = 16,
    parameter int WM_LEVEL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             word_wr,
    input  logic [31:0]      word_data,
    input  logic             tx_rst,
    input  logic             clr_done,
    output logic             txd,
    output logic             room,
    output logic             all_empty,
    output logic             done_flag,
    output logic             cnt_err
,   output logic             wm_low
);
    localparam int LW = $clog2(DEPTH + 1);

    logic              q_empty, q_full, q_pop;
    logic [31:0]       q_head;
    logic [LW-1:0]     fifo_level;
    logic              up_idle, done_pulse, ser_start, ser_ready;
    logic [LANE_W-1:0] ser_byte;
    logic              cnt_take;

    assign cnt_take = cnt_wr && q_empty && up_idle && !tx_rst;

    wptx_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_rst),
        .push  (word_wr),
        .wdata (word_data),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full),
        .level (fifo_level)
    );

    wptx_unpack #(.CNT_W(CNT_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (tx_rst),
        .cnt_load   (cnt_take),
        .cnt_val    (cnt_val),
        .q_empty    (q_empty),
        .q_head     (q_head),
        .ser_ready  (ser_ready),
        .q_pop      (q_pop),
        .ser_start  (ser_start),
        .ser_byte   (ser_byte),
        .idle       (up_idle),
        .done_pulse (done_pulse)
    );

    wptx_ser #(.BIT_CLKS(BIT_CLKS)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (tx_rst),
        .start (ser_start),
        .din   (ser_byte),
        .ready (ser_ready),
        .txd   (txd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            cnt_err   <= 1'b0;
        end else if (tx_rst) begin
            done_flag <= 1'b0;
            cnt_err   <= 1'b0;
        end else begin
            if (done_pulse)    done_flag <= 1'b1;
            else if (clr_done) done_flag <= 1'b0;
            if (cnt_wr && !cnt_take) cnt_err <= 1'b1;
        end
    end

    assign room      = !q_full;
    assign all_empty = q_empty && up_idle && ser_ready;
    assign wm_low    = (fifo_level <= LW'(WM_LEVEL));
endmodule

// File: rtl/wptx_chk.sv
module wptx_chk #(
    parameter int DEPTH = 4,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_wr,
    input logic          tx_rst,
    input logic          clr_done,
    input logic          txd,
    input logic          room,
    input logic          all_empty,
    input logic          done_flag,
    input logic          cnt_err,
    input logic          wm_low,
    input logic [LW-1:0] fifo_level
);
    // R3
    line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> txd);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(clr_done || tx_rst));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_err) |-> $past(cnt_wr));

    // R8
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (all_empty && !cnt_err && !done_flag && txd));

    // R9
    empty_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> room);

    // R10
    wm_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wm_low |-> room);
endmodule

bind wptx_top wptx_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH + 1))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .tx_rst     (tx_rst),
    .clr_done   (clr_done),
    .txd        (txd),
    .room       (room),
    .all_empty  (all_empty),
    .done_flag  (done_flag),
    .cnt_err    (cnt_err),
    .wm_low     (wm_low),
    .fifo_level (fifo_level)
);

// File: tb/sim_wptx_top.sv
module sim_wptx_top;
    localparam int DIV   = 4;
    localparam int DEPTH = 4;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic          word_wr = 1'b0;
    logic [31:0]   word_data = '0;
    logic          tx_rst = 1'b0;
    logic          clr_done = 1'b0;
    logic          txd, room, all_empty, done_flag, cnt_err, wm_low;

    int total = 0;
    int bad = 0;
    int frame_bad = 0;
    bit finished = 1'b0;
    logic [7:0] rx_q [$];

    always #10 clk = ~clk;

    wptx_top #(.BIT_CLKS(DIV), .DEPTH(DEPTH), .CNT_W(CW), .WM_LEVEL(0)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .word_wr(word_wr), .word_data(word_data), .tx_rst(tx_rst),
        .clr_done(clr_done), .txd(txd), .room(room), .all_empty(all_empty),
        .done_flag(done_flag), .cnt_err(cnt_err), .wm_low(wm_low)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // line monitor: samples each bit near its middle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                logic st_ok;
                @(negedge clk);
                st_ok = (txd === 1'b0);
                for (int k = 0; k < 8; k++) begin
                    repeat (DIV) @(negedge clk);
                    b[k] = txd;
                end
                repeat (DIV) @(negedge clk);
                if (!st_ok || txd !== 1'b1) frame_bad++;
                rx_q.push_back(b);
            end
        end
    end

    task automatic put_count(input int n);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_val = CW'(n);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        int guard = 0;
        while (!room && guard < 1000) begin @(negedge clk); guard++; end
        word_wr = 1'b1; word_data = w;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    task automatic force_word(input logic [31:0] w);
        word_wr = 1'b1; word_data = w;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_flag && n < 5000) begin @(negedge clk); n++; end
        chk(done_flag, tag, done_flag, 1);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1,       "R1 txd",       txd, 1);
        chk(room == 1'b1,      "R1 room",      room, 1);
        chk(all_empty == 1'b1, "R1 all_empty", all_empty, 1);
        chk(done_flag == 1'b0, "R1 done_flag", done_flag, 0);
        chk(cnt_err == 1'b0,   "R1 cnt_err",   cnt_err, 0);
        chk(wm_low == 1'b1,    "R1 wm_low",    wm_low, 1);
    endtask

    task automatic t_order;
        int low = 0;
        int n = 0;
        rx_q.delete();
        put_count(4);
        put_word(32'h4433_2211);
        while (txd !== 1'b0 && n < 100) begin @(negedge clk); n++; end
        while (txd === 1'b0 && low < 100) begin @(negedge clk); low++; end
        chk(low == DIV, "R3 start bit width", low, DIV);
        chk(all_empty == 1'b0, "R9 busy during frame", all_empty, 0);
        wait_done("R6 set after drain");
        chk(all_empty == 1'b1, "R9 empty after drain", all_empty, 1);
        chk(rx_q.size() == 4, "R2 byte count", rx_q.size(), 4);
        if (rx_q.size() == 4) begin
            chk(rx_q[0] == 8'h11, "R2 byte0", rx_q[0], 8'h11);
            chk(rx_q[1] == 8'h22, "R2 byte1", rx_q[1], 8'h22);
            chk(rx_q[2] == 8'h33, "R2 byte2", rx_q[2], 8'h33);
            chk(rx_q[3] == 8'h44, "R2 byte3", rx_q[3], 8'h44);
        end
    endtask

    task automatic t_clear;
        @(negedge clk);
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
        chk(done_flag == 1'b0, "R6 cleared by command", done_flag, 0);
    endtask

    task automatic t_trim;
        logic [7:0] exp [6] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF};
        rx_q.delete();
        put_count(6);
        put_word(32'hDDCC_BBAA);
        put_word(32'h8899_FFEE);
        wait_done("R6 set after two words");
        repeat (30 * DIV) @(negedge clk);
        chk(rx_q.size() == 6, "R4 exact count, trailing bytes dropped", rx_q.size(), 6);
        for (int i = 0; i < 6 && i < rx_q.size(); i++)
            chk(rx_q[i] == exp[i], "R4 byte value", rx_q[i], exp[i]);
    endtask

    task automatic t_full;
        rx_q.delete();
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) force_word(32'h0101_0101 * (i + 1));
        chk(room == 1'b0,      "R5 room low when full",  room, 0);
        chk(wm_low == 1'b0,    "R10 wm_low with words",  wm_low, 0);
        chk(all_empty == 1'b0, "R9 not empty with words", all_empty, 0);
        force_word(32'hDEAD_BEEF);
        chk(room == 1'b0, "R5 push to full queue", room, 0);
        put_count(3);
        chk(cnt_err == 1'b1, "R7 rejected count raises error", cnt_err, 1);
        repeat (20 * DIV) @(negedge clk);
        chk(rx_q.size() == 0, "R7 rejected count sends nothing", rx_q.size(), 0);
        chk(cnt_err == 1'b1, "R7 error is sticky", cnt_err, 1);
    endtask

    task automatic t_txreset;
        rx_q.delete();
        tx_rst = 1'b1;
        @(negedge clk);
        tx_rst = 1'b0;
        chk(all_empty == 1'b1, "R8 empty after command", all_empty, 1);
        chk(cnt_err == 1'b0,   "R8 error cleared",       cnt_err, 0);
        chk(done_flag == 1'b0, "R8 flag cleared",        done_flag, 0);
        chk(wm_low == 1'b1,    "R10 wm_low at level 0",  wm_low, 1);
        put_count(2);
        put_word(32'h0000_BEEF);
        wait_done("R8 transfer after command");
        chk(rx_q.size() == 2, "R8 old words flushed", rx_q.size(), 2);
        if (rx_q.size() == 2) begin
            chk(rx_q[0] == 8'hEF, "R8 byte0", rx_q[0], 8'hEF);
            chk(rx_q[1] == 8'hBE, "R8 byte1", rx_q[1], 8'hBE);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_clear();
        t_trim();
        t_full();
        t_txreset();
        chk(frame_bad == 0, "R3 framing of all characters", frame_bad, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule